// File: doc/BRIEF.md
# Packet Operand Fetch with Stall

This block supplies packet-derived operands to a rule engine that inspects a packet while the packet is still arriving. Received octets enter one per cycle on a byte stream with an end flag. They are kept in a sliding window buffer, and the block counts them. Each cycle a request names one of three operand kinds:
- a packet word, located by a base register plus a 5-bit offset;
- the end-of-packet flag;
- the running octet count.

The block answers in the same cycle. It returns either the masked 32-bit operand or a stall.

A packet word is four consecutive octets read most-significant first. A length code then trims it to its low (code+1) bits. A stall is raised when an octet has not arrived yet. It is also raised when an octet has already been pushed out of the window and the packet has not ended yet. Once the packet has ended, missing octets read as zero and the request proceeds. The end-of-packet operand blocks the request until the packet's end flag has been accepted.

Top module: `pkt_opnd_fetch`

## Requirements
- R1: The octet address is the selected base value plus `req_offset`. Selector code 0 is a virtual base that reads zero. Codes 1 to BASE_N pick `base_bus` slice code-1, where slice k is bits [k*CNT_W +: CNT_W]. Codes above BASE_N also read zero.
- R2: A packet operand is built as {oct[a], oct[a+1], oct[a+2], oct[a+3]}, with oct[a] in bits 31:24. It is then ANDed with a mask that keeps bits 0 to `req_bits` only. A `req_bits` value of 31 keeps all 32 bits.
- R3: A packet request stalls while any of its four octets has an index at or above the received count and the packet has not ended.
- R4: An octet whose index is below count-WIN has been overwritten. A request needing it stalls until the packet ends. After the end it proceeds, and that octet reads 0. An index exactly equal to count-WIN is still held.
- R5: After the end of a packet, octets at or beyond the count read 0 and cause no stall.
- R6: The end-of-packet request (`req_kind` 1) stalls until an octet flagged with `in_last` has been accepted. After that it returns 1.
- R7: The octet-count request (`req_kind` 2) returns the number of octets received in the current packet, masked as in R2. It never stalls, and the count increases by one per accepted octet.
- R8: When `req_valid` is low, or `req_kind` is 3, `stall` is 0 and `opnd_data` is 0. While `stall` is 1, `opnd_data` is 0.
- R9: An octet accepted after a completed packet starts a new packet. That octet is index 0, the count becomes 1, and the ended state clears unless that octet carries `in_last`.
- R10: After reset the count is 0 and no packet has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An octet is present on `in_octet` |
| in_octet | input | 8 | Received packet octet |
| in_last | input | 1 | The present octet ends a good packet |
| base_bus | input | BASE_N*CNT_W | Base register values, slice k holds base k+1 |
| req_valid | input | 1 | An operand is requested this cycle |
| req_kind | input | 2 | 0 packet word, 1 end of packet, 2 octet count, 3 none |
| req_base | input | 3 | Base selector |
| req_offset | input | 5 | Octet offset added to the base |
| req_bits | input | 5 | Length code, keeps bits 0..code |
| opnd_data | output | 32 | Operand value |
| stall | output | 1 | Operand cannot be supplied this cycle |

## Verification
The bench builds the block with a 16-octet window and a 12-bit count. With this setting a packet of about thirty octets pushes early octets out of the buffer. That brings the overwritten-octet stall, its exact boundary at count-WIN and the zero read-back after the end within a short run. Base values of 2, 5, 20 and 100 place requests inside the held window, past the received count, and far beyond the packet. These cover both stall reasons and the zero fill after the end.

// File: rtl/pof_pkg.sv
package pof_pkg;
   typedef enum logic [1:0] {
      OPK_PKT  = 2'd0,
      OPK_EOP  = 2'd1,
      OPK_CNT  = 2'd2,
      OPK_NONE = 2'd3
   } opnd_kind_e;

   localparam int OCTS_PER_WORD = 4;
   localparam int WORD_W        = 8 * OCTS_PER_WORD;
endpackage

// File: rtl/pof_octet_window.sv
module pof_octet_window #(
   parameter int WIN   = 64,
   parameter int CNT_W = 16,
   parameter int RD_N  = 4,
   localparam int LW   = $clog2(WIN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_octet,
   input  logic               in_last,
   input  logic [RD_N*LW-1:0] rd_idx,
   output logic [RD_N*8-1:0]  rd_octet,
   output logic [CNT_W-1:0]   octet_cnt,
   output logic               pkt_done
);
   logic [7:0]    mem [WIN];
   logic [LW-1:0] wr_idx;

   assign wr_idx = pkt_done ? '0 : octet_cnt[LW-1:0];

   always_ff @(posedge clk) begin
      if (in_valid) mem[wr_idx] <= in_octet;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         octet_cnt <= '0;
         pkt_done  <= 1'b0;
      end else if (in_valid) begin
         octet_cnt <= pkt_done ? CNT_W'(1) : octet_cnt + CNT_W'(1);
         pkt_done  <= in_last;
      end
   end

   for (genvar g = 0; g < RD_N; g++) begin : g_rd
      assign rd_octet[g*8 +: 8] = mem[rd_idx[g*LW +: LW]];
   end
endmodule

// File: rtl/pof_addr_gen.sv
module pof_addr_gen #(
   parameter int CNT_W  = 16,
   parameter int OFS_W  = 5,
   parameter int BASE_N = 4,
   parameter int SEL_W  = 3,
   parameter int AW     = CNT_W + 2
) (
   input  logic [BASE_N*CNT_W-1:0] base_bus,
   input  logic [SEL_W-1:0]        base_sel,
   input  logic [OFS_W-1:0]        offset,
   output logic [AW-1:0]           addr
);
   logic [BASE_N-1:0][CNT_W-1:0] hit_val;
   logic [CNT_W-1:0]             base_val;

   for (genvar g = 0; g < BASE_N; g++) begin : g_base
      assign hit_val[g] = (base_sel == SEL_W'(g + 1)) ? base_bus[g*CNT_W +: CNT_W] : '0;
   end

   always_comb begin
      base_val = '0;
      for (int k = 0; k < BASE_N; k++) base_val = base_val | hit_val[k];
   end

   assign addr = AW'(base_val) + AW'(offset);
endmodule

// File: rtl/pof_word_extract.sv
module pof_word_extract #(
   parameter int WIN   = 64,
   parameter int CNT_W = 16,
   parameter int AW    = CNT_W + 2,
   localparam int LW   = $clog2(WIN),
   localparam int NO   = pof_pkg::OCTS_PER_WORD
) (
   input  logic [AW-1:0]      addr,
   input  logic [CNT_W-1:0]   octet_cnt,
   input  logic               pkt_done,
   input  logic [NO*8-1:0]    rd_octet,
   output logic [NO*LW-1:0]   rd_idx,
   output logic [NO*8-1:0]    word,
   output logic               need_stall
);
   logic [AW-1:0] cnt_x;
   logic [NO-1:0] usable;

   assign cnt_x = AW'(octet_cnt);

   for (genvar g = 0; g < NO; g++) begin : g_oct
      logic [AW-1:0] a_g;
      logic          arrived, held;
      assign a_g     = addr + AW'(g);
      assign arrived = a_g < cnt_x;
      assign held    = (cnt_x <= AW'(WIN)) || ((a_g + AW'(WIN)) >= cnt_x);
      assign usable[g] = arrived && held;
      assign rd_idx[g*LW +: LW] = a_g[LW-1:0];
      assign word[(NO-1-g)*8 +: 8] = usable[g] ? rd_octet[g*8 +: 8] : 8'h00;
   end

   assign need_stall = !pkt_done && !(&usable);
endmodule

// File: rtl/pof_len_mask.sv
module pof_len_mask #(
   parameter int W  = 32,
   localparam int BW = $clog2(W)
) (
   input  logic [BW-1:0] len_code,
   output logic [W-1:0]  mask
);
   for (genvar g = 0; g < W; g++) begin : g_bit
      assign mask[g] = (BW'(g) <= len_code);
   end
endmodule

// File: rtl/pkt_opnd_fetch.sv
module pkt_opnd_fetch #(
   parameter int WIN    = 64,
   parameter int CNT_W  = 16,
   parameter int BASE_N = 4,
   localparam int AW    = CNT_W + 2,
   localparam int WW    = pof_pkg::WORD_W,
   localparam int NO    = pof_pkg::OCTS_PER_WORD,
   localparam int LW    = $clog2(WIN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [7:0]              in_octet,
   input  logic                    in_last,
   input  logic [BASE_N*CNT_W-1:0] base_bus,
   input  logic                    req_valid,
   input  logic [1:0]              req_kind,
   input  logic [2:0]              req_base,
   input  logic [4:0]              req_offset,
   input  logic [4:0]              req_bits,
   output logic [31:0]             opnd_data,
   output logic                    stall
);
   import pof_pkg::*;

   if ((WIN & (WIN - 1)) != 0 || WIN < NO) begin : g_bad_win
      $error("WIN must be a power of two of at least four");
   end
   if (CNT_W > WW || (1 << CNT_W) <= WIN) begin : g_bad_cnt
      $error("CNT_W must fit the word and exceed the window size");
   end
   if (BASE_N < 1 || BASE_N > 7) begin : g_bad_base
      $error("BASE_N must be between 1 and 7");
   end

   logic [NO*LW-1:0] rd_idx;
   logic [NO*8-1:0]  rd_octet;
   logic [CNT_W-1:0] octet_cnt;
   logic             pkt_done;
   logic [AW-1:0]    addr;
   logic [WW-1:0]    word, mask;
   logic             word_stall;
   opnd_kind_e       kind;

   assign kind = opnd_kind_e'(req_kind);

   pof_octet_window #(.WIN(WIN), .CNT_W(CNT_W), .RD_N(NO)) u_win (
      .clk, .rst_n, .in_valid, .in_octet, .in_last,
      .rd_idx, .rd_octet, .octet_cnt, .pkt_done
   );

   pof_addr_gen #(.CNT_W(CNT_W), .OFS_W(5), .BASE_N(BASE_N), .SEL_W(3), .AW(AW)) u_addr (
      .base_bus, .base_sel(req_base), .offset(req_offset), .addr
   );

   pof_word_extract #(.WIN(WIN), .CNT_W(CNT_W), .AW(AW)) u_ext (
      .addr, .octet_cnt, .pkt_done, .rd_octet, .rd_idx, .word, .need_stall(word_stall)
   );

   pof_len_mask #(.W(WW)) u_mask (.len_code(req_bits), .mask);

   always_comb begin
      stall     = 1'b0;
      opnd_data = '0;
      if (req_valid) begin
         unique case (kind)
            OPK_PKT: begin
               stall     = word_stall;
               opnd_data = word_stall ? '0 : (word & mask);
            end
            OPK_EOP: begin
               stall     = !pkt_done;
               opnd_data = pkt_done ? WW'(1) : '0;
            end
            OPK_CNT:  opnd_data = WW'(octet_cnt) & mask;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_last,
   input logic             req_valid,
   input logic [1:0]       req_kind,
   input logic [4:0]       req_bits,
   input logic [31:0]      opnd_data,
   input logic             stall,
   input logic [CNT_W-1:0] octet_cnt,
   input logic             pkt_done
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || req_kind == 2'd3) |-> (!stall && opnd_data == '0)); // R8
   AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> opnd_data == '0); // R8
   AST_EOP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd1 && !stall) |-> opnd_data == 32'd1); // R6
   AST_END_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> pkt_done); // R6
   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd1 && req_bits != 5'd31)
      |-> (opnd_data >> (6'(req_bits) + 6'd1)) == '0); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pkt_done) |=> octet_cnt == CNT_W'($past(octet_cnt) + CNT_W'(1))); // R7
   AST_CNT_NOSTALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2) |-> !stall); // R7
   AST_NEW_PKT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pkt_done) |=> octet_cnt == CNT_W'(1)); // R9
endmodule

bind pkt_opnd_fetch pof_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .req_valid(req_valid), .req_kind(req_kind), .req_bits(req_bits),
   .opnd_data(opnd_data), .stall(stall), .octet_cnt(octet_cnt), .pkt_done(pkt_done)
);

// File: tb/tb_pkt_opnd_fetch.sv
module tb_pkt_opnd_fetch;
   localparam int WIN = 16;
   localparam int CNT_W = 12;
   localparam int BASE_N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0;
   logic [7:0] in_octet = '0;
   logic [BASE_N*CNT_W-1:0] base_bus;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic [2:0] req_base = '0;
   logic [4:0] req_offset = '0, req_bits = '0;
   logic [31:0] opnd_data;
   logic stall;

   always #4 clk = ~clk;

   int bval [BASE_N] = '{2, 5, 20, 100};
   for (genvar g = 0; g < BASE_N; g++) begin : g_bb
      assign base_bus[g*CNT_W +: CNT_W] = CNT_W'(bval[g]);
   end

   pkt_opnd_fetch #(.WIN(WIN), .CNT_W(CNT_W), .BASE_N(BASE_N)) dut (
      .clk, .rst_n, .in_valid, .in_octet, .in_last, .base_bus,
      .req_valid, .req_kind, .req_base, .req_offset, .req_bits, .opnd_data, .stall
   );

   int n_chk = 0, n_fail = 0;
   int m_cnt = 0, m_pkt = 0;
   bit m_done = 0;
   bit finished = 0;

   function automatic logic [7:0] oct_val(int p, int i);
      return 8'(i * 37 + 11 + p * 91);
   endfunction

   function automatic void model(int kind, int bsel, int off, int bits,
                                 output logic [31:0] d, output logic st);
      logic [31:0] w, mk;
      int addr;
      bit ok, all_ok;
      mk = (bits == 31) ? 32'hFFFF_FFFF : ((32'd1 << (bits + 1)) - 32'd1);
      d = '0; st = 1'b0;
      if (kind == 0) begin
         addr = ((bsel >= 1 && bsel <= BASE_N) ? bval[bsel-1] : 0) + off;
         w = '0; all_ok = 1;
         for (int i = 0; i < 4; i++) begin
            ok = (addr + i < m_cnt) && (m_cnt <= WIN || addr + i + WIN >= m_cnt);
            if (ok) w[31-8*i -: 8] = oct_val(m_pkt, addr + i);
            else all_ok = 0;
         end
         st = !m_done && !all_ok;
         d = st ? '0 : (w & mk);
      end else if (kind == 1) begin
         st = !m_done;
         d = m_done ? 32'd1 : 32'd0;
      end else if (kind == 2) begin
         d = 32'(m_cnt) & mk;
      end
   endfunction

   task automatic check(string req, logic [31:0] ad, logic [31:0] ed, logic as, logic es);
      n_chk++;
      if (ad !== ed || as !== es) begin
         n_fail++;
         $display("FAIL %s: data=%h stall=%b expected data=%h stall=%b", req, ad, as, ed, es);
      end
   endtask

   task automatic send(logic [7:0] dummy, bit last);
      if (m_done) begin m_pkt++; m_cnt = 0; m_done = 0; end
      @(negedge clk);
      in_valid = 1'b1; in_octet = oct_val(m_pkt, m_cnt) ^ dummy; in_last = last;
      @(posedge clk); #1;
      in_valid = 1'b0; in_last = 1'b0;
      m_cnt++; m_done = last;
   endtask

   task automatic ask(int kind, int bsel, int off, int bits, string req);
      logic [31:0] ed; logic es;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(kind); req_base = 3'(bsel);
      req_offset = 5'(off); req_bits = 5'(bits);
      #1;
      model(kind, bsel, off, bits, ed, es);
      check(req, opnd_data, ed, stall, es);
      req_valid = 1'b0;
   endtask

   // {kind[1:0], base[2:0], offset[4:0], bits[4:0], expected stall}, with 10 octets held and no end
   localparam logic [15:0] VEC [12] = '{
      {2'd0, 3'd0, 5'd0,  5'd31, 1'b0},  // R1 R2 virtual base
      {2'd0, 3'd1, 5'd3,  5'd7,  1'b0},  // R1 R2
      {2'd0, 3'd2, 5'd2,  5'd15, 1'b1},  // R3 last octet missing
      {2'd0, 3'd2, 5'd1,  5'd0,  1'b0},  // R2 single bit
      {2'd0, 3'd3, 5'd0,  5'd31, 1'b1},  // R3
      {2'd1, 3'd0, 5'd0,  5'd0,  1'b1},  // R6
      {2'd2, 3'd0, 5'd0,  5'd31, 1'b0},  // R7
      {2'd2, 3'd0, 5'd0,  5'd1,  1'b0},  // R7 masked count
      {2'd0, 3'd5, 5'd4,  5'd15, 1'b0},  // R1 unused selector reads zero
      {2'd3, 3'd1, 5'd0,  5'd31, 1'b0},  // R8 kind none
      {2'd0, 3'd7, 5'd6,  5'd23, 1'b0},  // R1
      {2'd0, 3'd4, 5'd0,  5'd31, 1'b1}   // R3 far beyond
   };

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state seen through the operands
      ask(2, 0, 0, 31, "R10 count after reset");
      ask(1, 0, 0, 0,  "R10 no end after reset");
      @(negedge clk); #1;
      check("R8 idle output", opnd_data, 32'd0, stall, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 10; i++) send(8'h00, 1'b0);
      for (int v = 0; v < 12; v++) begin
         logic [31:0] ed; logic es;
         @(negedge clk);
         req_valid = 1'b1; req_kind = VEC[v][15:14]; req_base = VEC[v][13:11];
         req_offset = VEC[v][10:6]; req_bits = VEC[v][5:1];
         #1;
         model(int'(VEC[v][15:14]), int'(VEC[v][13:11]), int'(VEC[v][10:6]),
               int'(VEC[v][5:1]), ed, es);
         check($sformatf("R1-table entry %0d", v), opnd_data, ed, stall, VEC[v][0]);
         req_valid = 1'b0;
      end
      for (int i = 0; i < 20; i++) send(8'h00, 1'b0);
      ask(0, 0, 0, 31,  "R4 overwritten octet stalls");
      ask(0, 3, 6, 31,  "R2 word inside window");
      ask(0, 3, 9, 31,  "R3 tail not yet arrived");
      ask(0, 1, 12, 31, "R4 oldest held octet boundary");
      ask(0, 1, 11, 31, "R4 one below oldest stalls");
      send(8'h00, 1'b1);
      ask(1, 0, 0, 0,   "R6 end reads one");
      ask(0, 0, 0, 31,  "R4 overwritten after end reads zero");
      ask(0, 3, 9, 31,  "R5 zero fill past end");
      ask(0, 4, 0, 15,  "R5 far past end");
      ask(2, 0, 0, 31,  "R7 final count");
      send(8'h00, 1'b0);
      ask(2, 0, 0, 31,  "R9 new packet count");
      ask(1, 0, 0, 0,   "R9 end cleared");
      ask(0, 0, 0, 31,  "R3 new packet short");
      send(8'h00, 1'b0);
      send(8'h00, 1'b0);
      send(8'h00, 1'b1);
      ask(0, 0, 0, 31,  "R9 new packet word");
      ask(0, 0, 0, 11,  "R2 twelve bit mask");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule